// File: doc/BRIEF.md
# DRAM Self-Refresh Entry and Exit Sequencer

This block sits inside a DDR3-class memory controller and walks the memory device into self-refresh and back out. On an entry request it first waits for any data burst to finish, then forces on-die termination low. If any bank is still open it closes all of them, waits out the precharge recovery time, and then issues the self-refresh entry command with clock enable low. While the device is in self-refresh, CKE is held low. An exit request is honoured only after the minimum CKE-low time. After exit the block pads the bus with NOPs, issues a long ZQ calibration, and raises three readiness flags in turn: one for commands that do not need the DLL, one for DLL-dependent commands, and one for the first write.

The controller's own activates and precharges are fed in so that the block can follow which banks are open. These are plain control pins. There is no data stream and no back-pressure: `enter_req` and `exit_req` are levels that the controller holds until it sees the effect (CKE low, or `ready_basic`). All waits are cycle counts set by parameters. While the block is not in a sequence it drives NOP, and the controller's own commands are merged with it further downstream.

Top module: `selfrefresh_seq`

## Requirements
- R1: When an accepted entry finds a bank open, the block issues a precharge (cmd code 1) with `a10`=1 before the entry command. A bank counts as open after `act_valid` for it. It counts as closed after `pre_valid` with `pre_all`=1, or with `pre_all`=0 and `pre_bank` equal to that bank.
- R2: The self-refresh entry command (cmd code 2) appears only with `cke`=0, with no bank open, and at least T_RP cycles after the last precharge. With banks open it comes exactly T_RP+2 cycles after the request cycle. With all banks idle and recovery met it comes exactly 2 cycles after.
- R3: An entry request is not accepted while `burst_busy` is high. Acceptance happens in the first cycle in which `burst_busy` is low.
- R4: `odt` is 0 in the cycle of the entry command, in the cycle before it, and in every cycle while `cke` is 0.
- R5: `cke` stays 0 from the entry command until exit. It rises no earlier than T_CKESR cycles after the entry command. When exit is requested earlier, it rises exactly T_CKESR cycles after the entry command.
- R6: For T_XS cycles starting with the cycle in which `cke` rises, cmd is NOP (code 0). A ZQ long calibration (cmd code 3) is issued exactly T_XS cycles after the rise.
- R7: `ready_basic` is 0 from the cycle after an entry request is accepted until exit. It returns to 1 exactly T_XS+1 cycles after `cke` rises.
- R8: `ready_dll` returns to 1 exactly max(T_XSDLL, T_XS+1+T_ZQ) cycles after `cke` rises, and never earlier than T_XSDLL.
- R9: `ready_wr` returns to 1 exactly max(R8 point, T_WR_FIRST) cycles after `cke` rises.
- R10: `exit_req` has no effect outside self-refresh, and `enter_req` has no effect while a sequence is running.
- R11: After reset: `cke`=1, cmd NOP, and all three ready flags are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enter_req | input | 1 | Request to enter self-refresh (level) |
| exit_req | input | 1 | Request to leave self-refresh (level) |
| burst_busy | input | 1 | A read or write burst is in flight |
| odt_req | input | 1 | ODT level wanted by the controller in normal operation |
| act_valid | input | 1 | Controller issued an activate this cycle |
| act_bank | input | BA_W | Bank of that activate |
| pre_valid | input | 1 | Controller issued a precharge this cycle |
| pre_all | input | 1 | That precharge closes every bank |
| pre_bank | input | BA_W | Bank of a single-bank precharge |
| cke | output | 1 | Clock enable to the device |
| cmd | output | 3 | 0 NOP, 1 precharge, 2 self-refresh entry, 3 ZQ long calibration |
| a10 | output | 1 | Address bit 10 (1 = all banks on precharge) |
| ba | output | BA_W | Bank address (don't care for precharge-all, driven 0) |
| odt | output | 1 | On-die termination to the device |
| ready_basic | output | 1 | Commands that need no locked DLL may be issued |
| ready_dll | output | 1 | DLL-dependent commands may be issued |
| ready_wr | output | 1 | A write may be issued |

## Verification
The bench builds the block with T_RP=3, T_CKESR=5, T_XS=8, T_XSDLL=20, T_ZQ=6 and T_WR_FIRST=30. With these values the ZQ-limited point (15) lies below the DLL point (20), and the write point (30) lies beyond both, so each of the three readiness flags rises at its own distinct cycle. The short recovery times let many entry and exit rounds fit in a run. Each round has random open banks, random burst stalls, and exit requests both early and late. A per-cycle monitor checks the padding window, the CKE-low minimum and the ODT rule.

// File: rtl/srseq_pkg.sv
package srseq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PRE  = 3'd1,
    CMD_SRE  = 3'd2,
    CMD_ZQCL = 3'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ODT_OFF, ST_PRE, ST_WAIT_RP, ST_SRE, ST_SR, ST_XS, ST_ZQ
  } seq_st_e;
endpackage

// File: rtl/srseq_sat_counter.sv
module srseq_sat_counter #(
  parameter int W    = 8,
  parameter int MAXV = 100,
  parameter int CLRV = 0,
  parameter int RSTV = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAX_L = W'(MAXV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             count <= W'(RSTV);
    else if (clr)           count <= W'(CLRV);
    else if (count < MAX_L) count <= count + 1'b1;
  end
endmodule

// File: rtl/srseq_bank_track.sv
module srseq_bank_track #(
  parameter int NB   = 8,
  parameter int BA_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            act_valid,
  input  logic [BA_W-1:0] act_bank,
  input  logic            pre_valid,
  input  logic            pre_all,
  input  logic [BA_W-1:0] pre_bank,
  input  logic            close_all,
  output logic [NB-1:0]   open_mask,
  output logic            any_open
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic hit_act, hit_pre;
    assign hit_act = act_valid && (act_bank == BA_W'(b));
    assign hit_pre = close_all || (pre_valid && (pre_all || pre_bank == BA_W'(b)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       open_mask[b] <= 1'b0;
      else if (hit_pre) open_mask[b] <= 1'b0;
      else if (hit_act) open_mask[b] <= 1'b1;
    end
  end

  assign any_open = |open_mask;
endmodule

// File: rtl/selfrefresh_seq.sv
module selfrefresh_seq
  import srseq_pkg::*;
#(
  parameter int BA_W       = 3,
  parameter int T_RP       = 3,
  parameter int T_CKESR    = 5,
  parameter int T_XS       = 8,
  parameter int T_XSDLL    = 20,
  parameter int T_ZQ       = 6,
  parameter int T_WR_FIRST = 512
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enter_req,
  input  logic            exit_req,
  input  logic            burst_busy,
  input  logic            odt_req,
  input  logic            act_valid,
  input  logic [BA_W-1:0] act_bank,
  input  logic            pre_valid,
  input  logic            pre_all,
  input  logic [BA_W-1:0] pre_bank,
  output logic            cke,
  output logic [2:0]      cmd,
  output logic            a10,
  output logic [BA_W-1:0] ba,
  output logic            odt,
  output logic            ready_basic,
  output logic            ready_dll,
  output logic            ready_wr
);
  localparam int NB     = 1 << BA_W;
  localparam int ZQ_AT  = T_XS + 1 + T_ZQ;
  localparam int DLL_AT = (T_XSDLL > ZQ_AT) ? T_XSDLL : ZQ_AT;
  localparam int WR_AT  = (T_WR_FIRST > DLL_AT) ? T_WR_FIRST : DLL_AT;
  localparam int M1     = (WR_AT > T_RP) ? WR_AT : T_RP;
  localparam int XMAX   = (M1 > T_CKESR) ? M1 : T_CKESR;
  localparam int CW     = $clog2(XMAX + 2);

  seq_st_e st_q, st_d;
  logic [CW-1:0] rp_cnt, sr_cnt, x_cnt;
  logic [NB-1:0] open_mask;
  logic          any_open;
  logic          own_pre, rp_ok, exit_go;

  assign own_pre = (st_q == ST_PRE);
  assign rp_ok   = rp_cnt >= CW'(T_RP - 1);
  assign exit_go = (st_q == ST_SR) && exit_req && (sr_cnt >= CW'(T_CKESR - 1));

  srseq_bank_track #(.NB(NB), .BA_W(BA_W)) u_banks (
    .clk(clk), .rst_n(rst_n),
    .act_valid(act_valid), .act_bank(act_bank),
    .pre_valid(pre_valid), .pre_all(pre_all), .pre_bank(pre_bank),
    .close_all(own_pre), .open_mask(open_mask), .any_open(any_open)
  );

  // cycles since last precharge (1 in the cycle after it)
  srseq_sat_counter #(.W(CW), .MAXV(T_RP), .CLRV(1), .RSTV(T_RP)) u_rp_cnt (
    .clk(clk), .rst_n(rst_n), .clr(own_pre || pre_valid), .count(rp_cnt)
  );

  // cycles since the entry command
  srseq_sat_counter #(.W(CW), .MAXV(T_CKESR), .CLRV(1), .RSTV(0)) u_sr_cnt (
    .clk(clk), .rst_n(rst_n), .clr(st_q == ST_SRE), .count(sr_cnt)
  );

  // cycles since CKE rose (0 in the rising cycle)
  srseq_sat_counter #(.W(CW), .MAXV(XMAX), .CLRV(0), .RSTV(XMAX)) u_x_cnt (
    .clk(clk), .rst_n(rst_n), .clr(exit_go), .count(x_cnt)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (enter_req && !burst_busy) st_d = ST_ODT_OFF;
      ST_ODT_OFF: st_d = any_open ? ST_PRE : (rp_ok ? ST_SRE : ST_WAIT_RP);
      ST_PRE:     st_d = ST_WAIT_RP;
      ST_WAIT_RP: if (rp_ok) st_d = ST_SRE;
      ST_SRE:     st_d = ST_SR;
      ST_SR:      if (exit_go) st_d = ST_XS;
      ST_XS:      if (x_cnt >= CW'(T_XS - 1)) st_d = ST_ZQ;
      ST_ZQ:      st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    unique case (st_q)
      ST_PRE:  cmd = CMD_PRE;
      ST_SRE:  cmd = CMD_SRE;
      ST_ZQ:   cmd = CMD_ZQCL;
      default: cmd = CMD_NOP;
    endcase
  end

  assign cke         = !((st_q == ST_SRE) || (st_q == ST_SR));
  assign a10         = own_pre;
  assign ba          = '0;
  assign odt         = (st_q == ST_IDLE) && odt_req;
  assign ready_basic = (st_q == ST_IDLE);
  assign ready_dll   = ready_basic && (x_cnt >= CW'(DLL_AT));
  assign ready_wr    = ready_dll && (x_cnt >= CW'(WR_AT));

  // R1: a precharge from this block always closes every bank
  p_pre_all_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE) |-> a10);

  // R2: entry only with banks idle and recovery met
  p_sre_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_SRE) |-> (!cke && !any_open && rp_cnt >= CW'(T_RP)));

  // R4: termination off before and at entry
  p_odt_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_SRE) |-> (!odt && $past(!odt)));

  // R5: minimum CKE-low time before the rise
  p_ckesr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (sr_cnt >= CW'(T_CKESR)));

  // R6: only NOP inside the exit padding window
  p_xs_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && x_cnt < CW'(T_XS)) |-> (cmd == CMD_NOP && !ready_basic));

  // R8: DLL-dependent commands never before the DLL interval
  p_dll_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready_dll |-> (x_cnt >= CW'(T_XSDLL)));
endmodule

// File: tb/selfrefresh_seq_tb_top.sv
module selfrefresh_seq_tb_top;
  localparam int BA_W = 3, T_RP = 3, T_CKESR = 5, T_XS = 8, T_XSDLL = 20, T_ZQ = 6, T_WR_FIRST = 30;

  logic clk = 0, rst_n = 0;
  logic enter_req = 0, exit_req = 0, burst_busy = 0, odt_req = 0;
  logic act_valid = 0, pre_valid = 0, pre_all = 0;
  logic [BA_W-1:0] act_bank = '0, pre_bank = '0;
  logic cke, a10, odt, ready_basic, ready_dll, ready_wr;
  logic [2:0] cmd;
  logic [BA_W-1:0] ba;

  int checks = 0, failures = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  selfrefresh_seq #(.BA_W(BA_W), .T_RP(T_RP), .T_CKESR(T_CKESR), .T_XS(T_XS),
    .T_XSDLL(T_XSDLL), .T_ZQ(T_ZQ), .T_WR_FIRST(T_WR_FIRST)) dut_i (
    .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .exit_req(exit_req),
    .burst_busy(burst_busy), .odt_req(odt_req), .act_valid(act_valid),
    .act_bank(act_bank), .pre_valid(pre_valid), .pre_all(pre_all),
    .pre_bank(pre_bank), .cke(cke), .cmd(cmd), .a10(a10), .ba(ba), .odt(odt),
    .ready_basic(ready_basic), .ready_dll(ready_dll), .ready_wr(ready_wr));

  function automatic int max2(int a, int b); return (a > b) ? a : b; endfunction
  function automatic int exp_dll_at(); return max2(T_XSDLL, T_XS + 1 + T_ZQ); endfunction
  function automatic int exp_wr_at(); return max2(exp_dll_at(), T_WR_FIRST); endfunction
  function automatic int exp_sre_lat(bit banks_open); return banks_open ? T_RP + 2 : 2; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // per-cycle monitor, sampled at the falling edge
  logic [7:0] mask = '0;
  int since_pre = 1000, since_sre = 1000, since_rise = 1000;
  bit prev_cke = 1, prev_odt = 0, prev_rb = 1, prev_rd = 1, prev_rw = 1, exited = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (cke && !prev_cke) begin
        since_rise = 0; exited = 1;
        chk(since_sre >= T_CKESR, "R5 cke rise after CKESR", since_sre, T_CKESR);
      end
      if (!cke) begin
        chk(odt == 0, "R4 odt low in self-refresh", odt, 0);
        chk(ready_basic == 0, "R7 ready_basic low in self-refresh", ready_basic, 0);
        if (prev_cke) chk(cmd == 3'd2, "R5 cke falls with entry", cmd, 2);
      end
      if (cmd == 3'd2) begin
        chk(cke == 0, "R2 entry with cke low", cke, 0);
        chk(mask == 0, "R2 entry with banks idle", mask, 0);
        chk(since_pre >= T_RP, "R2 entry after tRP", since_pre, T_RP);
        chk(prev_odt == 0, "R4 odt low before entry", prev_odt, 0);
      end
      if (cmd == 3'd1) chk(a10 == 1, "R1 precharge-all a10", a10, 1);
      if (exited && cke && since_rise < T_XS)
        chk(cmd == 3'd0 && !ready_basic, "R6 NOP padding", cmd, 0);
      if (cmd == 3'd3) chk(since_rise == T_XS, "R6 ZQCL timing", since_rise, T_XS);
      if (ready_basic && !prev_rb) chk(since_rise == T_XS + 1, "R7 ready_basic rise", since_rise, T_XS + 1);
      if (ready_dll && !prev_rd) chk(since_rise == exp_dll_at(), "R8 ready_dll rise", since_rise, exp_dll_at());
      if (ready_wr && !prev_rw) chk(since_rise == exp_wr_at(), "R9 ready_wr rise", since_rise, exp_wr_at());
      if (ready_dll && exited) chk(since_rise >= T_XSDLL, "R8 ready_dll gate", since_rise, T_XSDLL);
      // bookkeeping for the next cycle
      if (cmd == 3'd1 || pre_valid) since_pre = 0;
      if (cmd == 3'd1) mask = '0;
      if (pre_valid) begin
        if (pre_all) mask = '0; else mask[pre_bank] = 1'b0;
      end
      if (act_valid) mask[act_bank] = 1'b1;
      if (cmd == 3'd2) since_sre = 0;
      if (since_pre < 1000) since_pre++;
      if (since_sre < 1000) since_sre++;
      if (since_rise < 1000) since_rise++;
      prev_cke = cke; prev_odt = odt; prev_rb = ready_basic; prev_rd = ready_dll; prev_rw = ready_wr;
    end
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic do_act(input int b);
    step(); act_valid = 1; act_bank = BA_W'(b);
    step(); act_valid = 0;
  endtask

  task automatic do_pre(input bit all, input int b);
    step(); pre_valid = 1; pre_all = all; pre_bank = BA_W'(b);
    step(); pre_valid = 0; pre_all = 0;
  endtask

  // raises enter_req and counts cycles until the entry command
  task automatic enter_and_measure(output int lat);
    step(); enter_req = 1; lat = 0;
    @(negedge clk);
    while (cmd != 3'd2 && lat < 200) begin @(negedge clk); lat++; end
    step(); enter_req = 0;
  endtask

  task automatic exit_and_settle();
    step(); exit_req = 1;
    while (!cke) step();
    exit_req = 0;
    while (!ready_wr) step();
  endtask

  initial begin
    int lat;
    int wd;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(cke == 1 && cmd == 0, "R11 reset cke/cmd", {cke, cmd}, 8);
    chk(ready_basic && ready_dll && ready_wr, "R11 reset ready flags", {ready_basic, ready_dll, ready_wr}, 7);

    // R10: exit request while awake has no effect
    step(); exit_req = 1;
    repeat (6) begin @(negedge clk); chk(cke == 1 && cmd == 0 && ready_basic, "R10 exit ignored when awake", cke, 1); end
    step(); exit_req = 0;

    // R2: entry with all banks idle
    enter_and_measure(lat);
    chk(lat == exp_sre_lat(0), "R2 entry latency idle banks", lat, exp_sre_lat(0));
    // R10: new entry request while in self-refresh has no effect; R5 early exit
    step(); enter_req = 1; exit_req = 1;
    while (!cke) step();
    chk(since_sre == T_CKESR + 1 || since_sre == T_CKESR, "R5 early exit rises at CKESR", since_sre, T_CKESR);
    enter_req = 0; exit_req = 0;
    while (!ready_wr) step();

    // R1: entry with banks open
    do_act(2); do_act(5);
    enter_and_measure(lat);
    chk(lat == exp_sre_lat(1), "R1 entry latency with open banks", lat, exp_sre_lat(1));
    exit_and_settle();

    // R3: burst in flight delays acceptance
    step(); burst_busy = 1; enter_req = 1;
    repeat (5) begin @(negedge clk); chk(ready_basic == 1 && cke == 1, "R3 held by burst", ready_basic, 1); end
    step(); burst_busy = 0; lat = 0;
    @(negedge clk);
    while (cmd != 3'd2 && lat < 200) begin @(negedge clk); lat++; end
    chk(lat == 2, "R3 entry after burst ends", lat, 2);
    step(); enter_req = 0;
    exit_and_settle();

    // R4: odt follows controller when idle
    step(); odt_req = 1;
    @(negedge clk); chk(odt == 1, "R4 odt passthrough idle", odt, 1);

    // random rounds
    void'($urandom(32'd12345));
    for (int it = 0; it < 25; it++) begin
      int nact = $urandom_range(0, 3);
      for (int k = 0; k < nact; k++) do_act($urandom_range(0, 7));
      if ($urandom_range(0, 1)) do_pre($urandom_range(0, 1), $urandom_range(0, 7));
      odt_req = 1'($urandom_range(0, 1));
      step(); burst_busy = 1'($urandom_range(0, 1)); enter_req = 1;
      repeat ($urandom_range(0, 4)) step();
      burst_busy = 0;
      while (cke) step();
      enter_req = 0;
      repeat ($urandom_range(0, 9)) step();
      exit_and_settle();
    end
    repeat (5) step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule